// File: doc/BRIEF.md
# Compressed Stream Delimiter Detector

This block sits on a 32-bit word stream of wavelet-coded video and labels every word it passes on. Each field of the stream opens with a two-word marker: an all-ones word, then a type word that names field one or field two. Each block inside a field opens with the same all-ones word, then a type word whose top byte names one of five block kinds. The three words after a field marker carry a time code. The single word after a block marker carries that block's bin width. All other words are coded payload, which is passed through with a payload tag. Markers only ever start on word boundaries, so the detector compares whole words and never searches at the bit level.

The all-ones word is held back for one word, and is then merged with the type word into one output beat that carries the marker kind. If the word after an all-ones word names no known type, the all-ones word is released as payload and a sticky format-error flag is set. The following word is then scanned from scratch, so it may itself open a marker. Words in a time-code or bin-width slot are never taken as a marker, whatever their value. This keeps coincidental all-ones patterns in those slots harmless. Both sides of the block use valid/ready handshakes, and a stalled output holds back the input without losing or repeating a word.

Top module: `delim_scan`

## Requirements
- R1: An all-ones word followed by 0x40000000 yields one beat with out_kind 1 (field one), and one followed by 0x41000000 yields one beat with out_kind 2 (field two). The beat's out_word is the type word, and the all-ones word yields no beat of its own.
- R2: An all-ones word followed by a word whose bits [31:24] are 0x81, 0x82, 0x83, 0x84 or 0x8F yields one beat with out_kind 3, 4, 5, 6 or 7 respectively. Bits [23:0] of that type word are not examined.
- R3: The three words after a field marker are emitted with out_kind 8 even when a word is all ones or looks like a type word. Once the third is emitted, out_tc equals {first, second, third}.
- R4: The one word after a block marker is emitted with out_kind 9, even when it is all ones, and out_bw then equals its bits [15:0].
- R5: Every other word is emitted unchanged with out_kind 0. out_payload is high exactly when out_kind is 0.
- R6: If an all-ones word is followed by a word that names no type, the all-ones word is emitted as out_kind 0 and out_fmt_err becomes 1 and stays 1 until reset. The following word is then scanned as if it were new, and it may itself start a marker.
- R7: While out_valid is high and out_ready is low, out_word and out_kind stay fixed. Every accepted input word shows up in the output sequence in order, exactly once (as its own beat or merged into a marker beat).
- R8: After reset, out_valid, out_fmt_err, out_tc and out_bw are all 0, and in_ready is high while in_valid is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input word present |
| in_ready | output | 1 | Input word accepted this cycle when high with in_valid |
| in_word | input | 32 | Input stream word |
| out_valid | output | 1 | Output beat present |
| out_ready | input | 1 | Downstream takes the beat |
| out_word | output | 32 | Output word (type word for marker beats) |
| out_kind | output | 4 | Beat label: 0 payload, 1-2 field, 3-7 block, 8 time code, 9 bin width |
| out_payload | output | 1 | High when the beat is payload |
| out_tc | output | 96 | Last captured time code |
| out_bw | output | 16 | Last captured bin width |
| out_fmt_err | output | 1 | Sticky malformed-marker flag |

## Verification
A word accepted at a clock edge appears on the output after that same edge, and so does the marker beat at the edge that accepts the type word. An all-ones word produces nothing at its own edge. The released all-ones beat of a malformed marker appears one edge before the word that follows it is accepted, with out_fmt_err rising at that same edge. out_tc and out_bw change at the edge that emits their last slot word, so the bench compares them against the expected beat at the moment that beat is handed over. Before each edge, the bench drives its inputs, waits for in_ready to settle, and predicts that edge's transfers. It then checks each output beat against a precomputed list at the cycle the handshake completes, under three backpressure patterns and with gaps in the input.

// File: rtl/dlm_pkg.sv
package dlm_pkg;

    localparam int WORD_W = 32;

    typedef enum logic [3:0] {
        K_DATA  = 4'd0,
        K_SOF1  = 4'd1,
        K_SOF2  = 4'd2,
        K_SOB1  = 4'd3,
        K_SOB2  = 4'd4,
        K_SOB3  = 4'd5,
        K_SOB4  = 4'd6,
        K_SOB5  = 4'd7,
        K_TCODE = 4'd8,
        K_BWID  = 4'd9
    } kind_e;

    typedef enum logic [1:0] {
        C_SCAN  = 2'd0,
        C_TCODE = 2'd1,
        C_BWID  = 2'd2
    } ctx_e;

    localparam logic [WORD_W-1:0] MARK_WORD = '1;
    localparam logic [WORD_W-1:0] FIELD1_WORD = 32'h4000_0000;
    localparam logic [WORD_W-1:0] FIELD2_WORD = 32'h4100_0000;
    localparam int NBLK = 5;

    function automatic logic [7:0] blk_tag(input int i);
        return (i < 4) ? 8'(8'h81 + i) : 8'h8F;
    endfunction

endpackage

// File: rtl/dlm_type_decode.sv
module dlm_type_decode
    import dlm_pkg::*;
(
    input  logic [WORD_W-1:0] word,
    output logic              hit,
    output logic              is_field,
    output kind_e             kind
);

    always_comb begin
        hit      = 1'b0;
        is_field = 1'b0;
        kind     = K_DATA;
        if (word == FIELD1_WORD) begin
            hit      = 1'b1;
            is_field = 1'b1;
            kind     = K_SOF1;
        end else if (word == FIELD2_WORD) begin
            hit      = 1'b1;
            is_field = 1'b1;
            kind     = K_SOF2;
        end else begin
            for (int i = 0; i < NBLK; i++) begin
                if (word[WORD_W-1 -: 8] == blk_tag(i)) begin
                    hit  = 1'b1;
                    kind = kind_e'(4'(int'(K_SOB1) + i));
                end
            end
        end
    end

    // R2: a recognised type never maps to the payload label
    always_comb begin
        a_r2_hit_kind: assert (!hit || kind != K_DATA);
    end

endmodule

// File: rtl/dlm_capture.sv
module dlm_capture
    import dlm_pkg::*;
#(
    parameter int TC_WORDS = 3,
    parameter int BW_W     = 16,
    localparam int TC_W    = TC_WORDS * WORD_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tc_en,
    input  logic              bw_en,
    input  logic [WORD_W-1:0] word,
    output logic [TC_W-1:0]   tc,
    output logic [BW_W-1:0]   bw
);

    logic [TC_W-1:0] tc_d, tc_q;
    logic [BW_W-1:0] bw_d, bw_q;

    generate
        if (TC_WORDS == 1) begin : g_tc_one
            always_comb tc_d = tc_en ? word : tc_q;
        end else begin : g_tc_shift
            always_comb tc_d = tc_en ? {tc_q[TC_W-WORD_W-1:0], word} : tc_q;
        end
    endgenerate

    always_comb bw_d = bw_en ? word[BW_W-1:0] : bw_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tc_q <= '0;
            bw_q <= '0;
        end else begin
            tc_q <= tc_d;
            bw_q <= bw_d;
        end
    end

    assign tc = tc_q;
    assign bw = bw_q;

    // R4: bin width changes only on a bin-width slot
    a_r4_bw_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !bw_en |=> $stable(bw_q));

    // R3: time code changes only on a time-code slot
    a_r3_tc_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !tc_en |=> $stable(tc_q));

endmodule

// File: rtl/delim_scan.sv
module delim_scan
    import dlm_pkg::*;
#(
    parameter int TC_WORDS = 3,
    parameter int BW_W     = 16,
    localparam int TC_W    = TC_WORDS * WORD_W,
    localparam int CNT_W   = $clog2(TC_WORDS + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [WORD_W-1:0] in_word,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [WORD_W-1:0] out_word,
    output logic [3:0]        out_kind,
    output logic              out_payload,
    output logic [TC_W-1:0]   out_tc,
    output logic [BW_W-1:0]   out_bw,
    output logic              out_fmt_err
);

    typedef struct packed {
        ctx_e              ctx;
        logic [CNT_W-1:0]  cnt;
        logic              pend;
        logic              ov;
        logic [WORD_W-1:0] oword;
        kind_e             okind;
        logic              err;
    } st_t;

    st_t   st_d, st_q;
    logic  hit, is_field;
    kind_e dec_kind;
    logic  can_emit, flush, fire, tc_en, bw_en;

    dlm_type_decode u_dec (
        .word     (in_word),
        .hit      (hit),
        .is_field (is_field),
        .kind     (dec_kind)
    );

    dlm_capture #(.TC_WORDS(TC_WORDS), .BW_W(BW_W)) u_cap (
        .clk   (clk),
        .rst_n (rst_n),
        .tc_en (tc_en),
        .bw_en (bw_en),
        .word  (in_word),
        .tc    (out_tc),
        .bw    (out_bw)
    );

    always_comb begin
        can_emit = !st_q.ov || out_ready;
        flush    = st_q.pend && in_valid && !hit;
        in_ready = can_emit && !flush;
        fire     = in_valid && in_ready;
        st_d     = st_q;
        tc_en    = 1'b0;
        bw_en    = 1'b0;
        if (can_emit) st_d.ov = 1'b0;
        if (can_emit && flush) begin
            st_d.ov    = 1'b1;
            st_d.oword = MARK_WORD;
            st_d.okind = K_DATA;
            st_d.pend  = 1'b0;
            st_d.err   = 1'b1;
        end else if (fire) begin
            unique case (st_q.ctx)
                C_TCODE: begin
                    st_d.ov    = 1'b1;
                    st_d.oword = in_word;
                    st_d.okind = K_TCODE;
                    tc_en      = 1'b1;
                    if (st_q.cnt == CNT_W'(TC_WORDS - 1)) begin
                        st_d.ctx = C_SCAN;
                        st_d.cnt = '0;
                    end else begin
                        st_d.cnt = st_q.cnt + 1'b1;
                    end
                end
                C_BWID: begin
                    st_d.ov    = 1'b1;
                    st_d.oword = in_word;
                    st_d.okind = K_BWID;
                    bw_en      = 1'b1;
                    st_d.ctx   = C_SCAN;
                end
                default: begin
                    if (st_q.pend) begin
                        st_d.ov    = 1'b1;
                        st_d.oword = in_word;
                        st_d.okind = dec_kind;
                        st_d.pend  = 1'b0;
                        st_d.ctx   = is_field ? C_TCODE : C_BWID;
                        st_d.cnt   = '0;
                    end else if (in_word == MARK_WORD) begin
                        st_d.pend = 1'b1;
                    end else begin
                        st_d.ov    = 1'b1;
                        st_d.oword = in_word;
                        st_d.okind = K_DATA;
                    end
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_valid   = st_q.ov;
    assign out_word    = st_q.oword;
    assign out_kind    = st_q.okind;
    assign out_payload = (st_q.okind == K_DATA);
    assign out_fmt_err = st_q.err;

    // R7: a stalled beat is held unchanged
    a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_word) && $stable(out_kind));

    // R6: the format-error flag never clears before reset
    a_r6_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        out_fmt_err |=> out_fmt_err);

    // R6: a malformed marker releases the all-ones word as payload
    a_r6_flush: assert property (@(posedge clk) disable iff (!rst_n)
        flush && can_emit |=> out_valid && out_word == MARK_WORD && out_kind == K_DATA && !st_q.pend);

    // R3: a held marker word exists only while scanning
    a_r3_pend_scan: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.pend |-> st_q.ctx == C_SCAN);

    // R1: a completed marker leaves the scan context
    a_r1_leave_scan: assert property (@(posedge clk) disable iff (!rst_n)
        fire && st_q.pend |=> st_q.ctx != C_SCAN && out_kind != K_DATA);

endmodule

// File: tb/sim_delim_scan.sv
module sim_delim_scan;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [31:0] in_word = '0;
    logic        out_valid;
    logic        out_ready = 1'b0;
    logic [31:0] out_word;
    logic [3:0]  out_kind;
    logic        out_payload;
    logic [95:0] out_tc;
    logic [15:0] out_bw;
    logic        out_fmt_err;

    always #10 clk = ~clk;

    delim_scan u0 (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_ready(in_ready), .in_word(in_word),
        .out_valid(out_valid), .out_ready(out_ready), .out_word(out_word),
        .out_kind(out_kind), .out_payload(out_payload), .out_tc(out_tc),
        .out_bw(out_bw), .out_fmt_err(out_fmt_err)
    );

    localparam int MAXN = 1024;
    localparam int WD   = 100000;

    logic [31:0] iw   [MAXN];
    logic [31:0] ew   [MAXN];
    logic [3:0]  ek   [MAXN];
    logic        etcc [MAXN];
    logic [95:0] etc  [MAXN];
    logic        ebwc [MAXN];
    logic [15:0] ebw  [MAXN];
    logic        eerr [MAXN];
    int ni = 0, ne = 0, ndat = 0;
    logic err_seen = 1'b0;
    int n_chk = 0, n_fail = 0;

    task automatic check(input logic ok, input string req, input logic [127:0] act, input logic [127:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic push_in(input logic [31:0] w);
        iw[ni] = w;
        ni++;
    endtask

    task automatic push_exp(input logic [31:0] w, input logic [3:0] k, input logic tcc,
                            input logic [95:0] tc, input logic bwc, input logic [15:0] bw);
        ew[ne] = w; ek[ne] = k; etcc[ne] = tcc; etc[ne] = tc;
        ebwc[ne] = bwc; ebw[ne] = bw; eerr[ne] = err_seen;
        ne++;
    endtask

    // R5: plain payload word, top byte 0x10 so it never names a type
    task automatic t_data();
        logic [31:0] w = 32'h1000_0000 + ndat * 32'h0001_0203;
        ndat++;
        push_in(w);
        push_exp(w, 4'd0, 1'b0, '0, 1'b0, '0);
    endtask

    // R1 and R3: field marker then three time-code words
    task automatic t_field(input bit sel, input logic [31:0] a, input logic [31:0] b, input logic [31:0] c);
        logic [31:0] tw = sel ? 32'h4100_0000 : 32'h4000_0000;
        push_in(32'hFFFF_FFFF);
        push_in(tw);
        push_exp(tw, sel ? 4'd2 : 4'd1, 1'b0, '0, 1'b0, '0);
        push_in(a); push_exp(a, 4'd8, 1'b0, '0, 1'b0, '0);
        push_in(b); push_exp(b, 4'd8, 1'b0, '0, 1'b0, '0);
        push_in(c); push_exp(c, 4'd8, 1'b1, {a, b, c}, 1'b0, '0);
    endtask

    // R2 and R4: block marker then one bin-width word
    task automatic t_block(input int idx, input logic [23:0] low, input logic [31:0] bww);
        logic [7:0]  tag = (idx < 4) ? 8'(8'h81 + idx) : 8'h8F;
        logic [31:0] tw  = {tag, low};
        push_in(32'hFFFF_FFFF);
        push_in(tw);
        push_exp(tw, 4'(3 + idx), 1'b0, '0, 1'b0, '0);
        push_in(bww);
        push_exp(bww, 4'd9, 1'b0, '0, 1'b1, bww[15:0]);
    endtask

    // R6: all-ones word followed by a word naming no type
    task automatic t_bad(input logic [31:0] w);
        push_in(32'hFFFF_FFFF);
        err_seen = 1'b1;
        push_exp(32'hFFFF_FFFF, 4'd0, 1'b0, '0, 1'b0, '0);
        push_in(w);
        push_exp(w, 4'd0, 1'b0, '0, 1'b0, '0);
    endtask

    // R6: lone all-ones word; the caller follows it with a fresh marker
    task automatic t_lone();
        push_in(32'hFFFF_FFFF);
        err_seen = 1'b1;
        push_exp(32'hFFFF_FFFF, 4'd0, 1'b0, '0, 1'b0, '0);
    endtask

    initial begin
        int  iidx, oidx, cyc, mode;
        logic fire_in;

        for (int rep = 0; rep < 3; rep++) begin
            for (int s = 0; s < 2; s++) begin
                t_data();
                t_field(s[0], 32'h0A0B_0C00 + rep, 32'h1234_5678 ^ s, 32'h00C0_FFEE + rep);
                for (int b = 0; b < 5; b++) begin
                    t_block(b, 24'(rep * 5 + b), 32'h5500_0000 + 32'(b * 16'h1111 + rep));
                    t_data();
                end
            end
            t_field(1'b0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h4000_0000);
            t_block(2, 24'hFFFFFF, 32'hFFFF_FFFF);
            t_data();
            if (rep > 0) begin
                t_bad(32'h4200_0000);
                t_bad(32'h8500_0000);
                t_bad(32'h4000_0001);
                t_bad(32'h0000_0000);
                t_lone();
                t_field(1'b1, 32'h1111_1111, 32'h2222_2222, 32'h3333_3333);
                t_lone();
                t_block(4, 24'h000001, 32'h0000_ABCD);
            end
            t_data();
        end

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(out_valid == 1'b0, "R8 out_valid", 128'(out_valid), 128'd0);
        check(in_ready == 1'b1, "R8 in_ready", 128'(in_ready), 128'd1);
        check(out_fmt_err == 1'b0, "R8 out_fmt_err", 128'(out_fmt_err), 128'd0);
        check(out_tc == '0, "R8 out_tc", 128'(out_tc), 128'd0);
        check(out_bw == '0, "R8 out_bw", 128'(out_bw), 128'd0);

        iidx = 0; oidx = 0; cyc = 0; fire_in = 1'b0;
        while (oidx < ne && cyc < WD) begin
            @(negedge clk);
            cyc++;
            if (fire_in) iidx++;
            mode = (cyc / 150) % 3;
            if (!in_valid || fire_in) begin
                if (iidx < ni && !(mode == 2 && ($urandom % 4) == 0)) begin
                    in_valid = 1'b1;
                    in_word  = iw[iidx];
                end else begin
                    in_valid = 1'b0;
                end
            end
            out_ready = (mode == 0) ? 1'b1 : (mode == 1) ? (cyc % 3 != 0) : 1'($urandom % 2);
            #1;
            fire_in = in_valid && in_ready;
            if (out_valid && out_ready) begin
                check(out_word == ew[oidx], "R7 word order", 128'(out_word), 128'(ew[oidx]));
                check(out_kind == ek[oidx], "R1 R2 R3 R4 R5 kind", 128'(out_kind), 128'(ek[oidx]));
                check(out_payload == (ek[oidx] == 4'd0), "R5 payload flag", 128'(out_payload), 128'(ek[oidx] == 4'd0));
                check(out_fmt_err == eerr[oidx], "R6 error flag", 128'(out_fmt_err), 128'(eerr[oidx]));
                if (etcc[oidx])
                    check(out_tc == etc[oidx], "R3 time code", 128'(out_tc), 128'(etc[oidx]));
                if (ebwc[oidx])
                    check(out_bw == ebw[oidx], "R4 bin width", 128'(out_bw), 128'(ebw[oidx]));
                oidx++;
            end
        end
        if (cyc >= WD) check(1'b0, "watchdog", 128'(oidx), 128'(ne));

        in_valid  = 1'b0;
        out_ready = 1'b1;
        if (fire_in) iidx++;
        repeat (4) @(negedge clk);
        check(iidx == ni, "R7 all inputs taken", 128'(iidx), 128'(ni));
        check(out_valid == 1'b0, "R7 no extra beat", 128'(out_valid), 128'd0);

        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

endmodule